// File: doc/BRIEF.md
# Banked Instruction Memory Bus Interface

This block stores eight instructions of 48 bits each. Each instruction is made of three 16-bit sections: a control section, a first limit section and a second limit section. A host processor reaches the store one section at a time through a parallel bus that runs either 16 bits wide or 8 bits wide. The bus address selects the instruction, and in 8-bit mode it also selects the byte. A two-bit section pointer, held in a configuration register, selects which of the three sections an access hits. The host may fill and read the store in any order.

A second read port returns a whole 48-bit instruction to the sequencer that executes the program. The configuration register models only three things: the section pointer (bits 9:8), a soft-reset request strobe (bit 1) and a clear for the access-violation flag (bit 2). After it touches the store, the host is expected to issue a soft-reset request. A host access made while the sequencer reports that it is running still completes, but it sets a sticky violation flag.

Top module: `bim_top`

## Requirements
- R1: After a synchronous reset, every instruction reads as zero on both ports, `cfg_ptr` is 00, `access_violation` is 0, `soft_reset_req` is 0 and `host_rdata` is 0.
- R2: In 16-bit mode (`bus_is_byte`=0), `host_addr[4:1]` selects the instruction and `host_addr[0]` is ignored. A write stores all 16 bits of `host_wdata` into the section chosen by `cfg_ptr`. A read returns that section on `host_rdata` at the clock edge that samples the request.
- R3: Pointer 00 maps to instruction bits 15:0, pointer 01 to bits 31:16 and pointer 10 to bits 47:32. A write to one section leaves the other two sections of the same instruction unchanged.
- R4: In 8-bit mode (`bus_is_byte`=1), `host_addr[3:1]` selects the instruction. `host_addr[0]`=0 selects the low byte of the section and 1 selects the high byte. A write changes only that byte, taking it from `host_wdata[7:0]`. A read returns the byte in `host_rdata[7:0]` with bits 15:8 at zero.
- R5: Pointer value 11 is reserved. A write made with it changes no stored bit, and a read made with it returns zero.
- R6: An address with `host_addr[4]`=1 is outside the store in both bus modes. A write to it changes nothing, and a read from it returns zero.
- R7: `seq_instr` presents the full 48-bit instruction chosen by `seq_idx`, registered, one clock after `seq_idx` is sampled.
- R8: A host access (`host_en`=1) made while `seq_running`=1 sets `access_violation`, and the access still completes. The flag stays set until a configuration write with bit 2 at 1. If a new violation arrives in the same cycle as the clear, the flag stays set.
- R9: A configuration write with bit 1 at 1 drives `soft_reset_req` high for exactly the next cycle.
- R10: A configuration write loads `cfg_ptr` from `cfg_wdata[9:8]`. Without a configuration write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_is_byte | input | 1 | Bus width select: 0 = 16-bit, 1 = 8-bit |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Host address A4..A0 |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration data: bits 9:8 pointer, bit 1 soft reset, bit 2 violation clear |
| cfg_ptr | output | 2 | Current section pointer |
| soft_reset_req | output | 1 | One-cycle soft-reset request to the sequencer |
| seq_running | input | 1 | Sequencer busy indication |
| access_violation | output | 1 | Sticky flag: host accessed the store while the sequencer ran |
| seq_idx | input | 3 | Sequencer instruction index |
| seq_instr | output | 48 | Registered full instruction for the sequencer |

## Verification
The store is filled through the 16-bit path with data that differs for every instruction, so a misdecoded index shows up on readback and on the sequencer port. The same instruction is then written through each pointer value, which separates correct section placement from overlap between sections. Byte-mode writes to the low byte and then the high byte of one section tell a correct lane select from a swapped or full-width write. Reserved-pointer and out-of-range accesses are followed by reads on the sequencer port, which show that no stored bit moved. The violation flag is set, held, cleared, and hit with a clear and a new violation in the same cycle, which checks its set-over-clear priority.

// File: rtl/bim_pkg.sv
package bim_pkg;

    parameter int unsigned NUM_INSTR = 8;
    parameter int unsigned NUM_SEC   = 3;
    parameter int unsigned SEC_W     = 16;
    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned ADDR_W    = 5;
    parameter int unsigned CFG_W     = 16;

    localparam int unsigned IDX_W   = $clog2(NUM_INSTR);
    localparam int unsigned INSTR_W = SEC_W * NUM_SEC;
    localparam int unsigned LANES   = SEC_W / BYTE_W;
    localparam int unsigned PTR_W   = 2;
    localparam int unsigned WORD_W  = ADDR_W - 1;

    // configuration register field positions
    localparam int unsigned CFG_PTR_LO  = 8;
    localparam int unsigned CFG_SRST    = 1;
    localparam int unsigned CFG_VCLR    = 2;

    typedef enum logic [PTR_W-1:0] {
        SEC_CTRL = 2'b00,
        SEC_LIM1 = 2'b01,
        SEC_LIM2 = 2'b10,
        SEC_RSVD = 2'b11
    } sec_sel_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        sec_sel_e         sec;
        logic [LANES-1:0] lane_en;
        logic             hi_byte;
    } host_tgt_t;

    typedef struct packed {
        sec_sel_e ptr;
        logic     srst;
        logic     vclr;
    } cfg_fields_t;

    function automatic host_tgt_t decode_host(
        input logic [ADDR_W-1:0] addr,
        input logic              is_byte,
        input sec_sel_e          ptr
    );
        host_tgt_t         t;
        logic [WORD_W-1:0] word;
        word      = addr[ADDR_W-1:1];
        t.hit     = (32'(word) < NUM_INSTR) && (32'(ptr) < NUM_SEC);
        t.idx     = word[IDX_W-1:0];
        t.sec     = ptr;
        t.hi_byte = is_byte & addr[0];
        if (!is_byte)
            t.lane_en = '1;
        else if (addr[0])
            t.lane_en = LANES'(2'b10);
        else
            t.lane_en = LANES'(2'b01);
        return t;
    endfunction

    function automatic cfg_fields_t decode_cfg(input logic [CFG_W-1:0] d);
        cfg_fields_t f;
        f.ptr  = sec_sel_e'(d[CFG_PTR_LO +: PTR_W]);
        f.srst = d[CFG_SRST];
        f.vclr = d[CFG_VCLR];
        return f;
    endfunction

    function automatic logic [SEC_W-1:0] shape_read(
        input logic [SEC_W-1:0] sec_data,
        input logic             is_byte,
        input logic             hi_byte
    );
        logic [SEC_W-1:0] r;
        if (!is_byte)
            r = sec_data;
        else if (hi_byte)
            r = {{(SEC_W-BYTE_W){1'b0}}, sec_data[SEC_W-1 -: BYTE_W]};
        else
            r = {{(SEC_W-BYTE_W){1'b0}}, sec_data[BYTE_W-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/bim_addr_decode.sv
module bim_addr_decode
    import bim_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_byte,
    input  sec_sel_e          ptr,
    output host_tgt_t         tgt
);
    always_comb begin
        tgt = decode_host(addr, is_byte, ptr);
    end
endmodule

// File: rtl/bim_store.sv
module bim_store
    import bim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  sec_sel_e            wr_sec,
    input  logic [LANES-1:0]    wr_lane_en,
    input  logic [SEC_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    input  sec_sel_e            rd_sec,
    output logic [SEC_W-1:0]    rd_data,
    input  logic [IDX_W-1:0]    seq_idx,
    output logic [INSTR_W-1:0]  seq_instr
);
    logic [NUM_INSTR-1:0][INSTR_W-1:0] inst_flat;

    for (genvar gi = 0; gi < NUM_INSTR; gi++) begin : g_instr
        for (genvar gs = 0; gs < NUM_SEC; gs++) begin : g_sec
            logic sec_hit;
            assign sec_hit = wr_en && (wr_idx == IDX_W'(gi)) && (wr_sec == sec_sel_e'(gs));
            for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
                logic [BYTE_W-1:0] cell_q;
                always_ff @(posedge clk) begin
                    if (rst)
                        cell_q <= '0;
                    else if (sec_hit && wr_lane_en[gl])
                        cell_q <= wr_data[gl*BYTE_W +: BYTE_W];
                end
                assign inst_flat[gi][(gs*SEC_W)+(gl*BYTE_W) +: BYTE_W] = cell_q;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SEC; s++) begin
            if (rd_sec == sec_sel_e'(s))
                rd_data = inst_flat[rd_idx][s*SEC_W +: SEC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            seq_instr <= '0;
        else
            seq_instr <= inst_flat[seq_idx];
    end
endmodule

// File: rtl/bim_cfg.sv
module bim_cfg
    import bim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             host_access,
    input  logic             seq_running,
    output sec_sel_e         ptr,
    output logic             soft_reset_req,
    output logic             access_violation
);
    cfg_fields_t fields;
    logic        viol_set;
    logic        viol_clr;

    always_comb begin
        fields   = decode_cfg(cfg_wdata);
        viol_set = host_access && seq_running;
        viol_clr = cfg_we && fields.vclr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr              <= SEC_CTRL;
            soft_reset_req   <= 1'b0;
            access_violation <= 1'b0;
        end else begin
            if (cfg_we)
                ptr <= fields.ptr;
            soft_reset_req   <= cfg_we && fields.srst;
            access_violation <= viol_set || (access_violation && !viol_clr);
        end
    end
endmodule

// File: rtl/bim_top.sv
module bim_top
    import bim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_is_byte,
    input  logic                 host_en,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [SEC_W-1:0]     host_wdata,
    output logic [SEC_W-1:0]     host_rdata,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [PTR_W-1:0]     cfg_ptr,
    output logic                 soft_reset_req,
    input  logic                 seq_running,
    output logic                 access_violation,
    input  logic [IDX_W-1:0]     seq_idx,
    output logic [INSTR_W-1:0]   seq_instr
);
    sec_sel_e         ptr;
    host_tgt_t        tgt;
    logic [SEC_W-1:0] wr_lanes;
    logic [SEC_W-1:0] sec_rd;
    logic             do_write;

    bim_cfg u_cfg (
        .clk              (clk),
        .rst              (rst),
        .cfg_we           (cfg_we),
        .cfg_wdata        (cfg_wdata),
        .host_access      (host_en),
        .seq_running      (seq_running),
        .ptr              (ptr),
        .soft_reset_req   (soft_reset_req),
        .access_violation (access_violation)
    );

    bim_addr_decode u_dec (
        .addr    (host_addr),
        .is_byte (bus_is_byte),
        .ptr     (ptr),
        .tgt     (tgt)
    );

    always_comb begin
        wr_lanes = bus_is_byte ? {LANES{host_wdata[BYTE_W-1:0]}} : host_wdata;
        do_write = host_en && host_we && tgt.hit;
    end

    bim_store u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (do_write),
        .wr_idx     (tgt.idx),
        .wr_sec     (tgt.sec),
        .wr_lane_en (tgt.lane_en),
        .wr_data    (wr_lanes),
        .rd_idx     (tgt.idx),
        .rd_sec     (tgt.sec),
        .rd_data    (sec_rd),
        .seq_idx    (seq_idx),
        .seq_instr  (seq_instr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_en && !host_we)
            host_rdata <= tgt.hit ? shape_read(sec_rd, bus_is_byte, tgt.hi_byte) : '0;
    end

    assign cfg_ptr = ptr;
endmodule

// File: rtl/bim_checker.sv
module bim_checker
    import bim_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_is_byte,
    input logic               host_en,
    input logic               host_we,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [SEC_W-1:0]   host_rdata,
    input logic               cfg_we,
    input logic [CFG_W-1:0]   cfg_wdata,
    input logic [PTR_W-1:0]   cfg_ptr,
    input logic               soft_reset_req,
    input logic               seq_running,
    input logic               access_violation
);
    p_reserved_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (host_en && !host_we && cfg_ptr == 2'b11) |=> host_rdata == '0);

    p_out_of_range_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (host_en && !host_we && host_addr[ADDR_W-1]) |=> host_rdata == '0);

    p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (host_en && !host_we && bus_is_byte) |=> host_rdata[SEC_W-1:BYTE_W] == '0);

    p_viol_set_r8: assert property (@(posedge clk) disable iff (rst)
        (host_en && seq_running) |=> access_violation);

    p_viol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (access_violation && !(cfg_we && cfg_wdata[CFG_VCLR])) |=> access_violation);

    p_soft_reset_cause_r9: assert property (@(posedge clk) disable iff (rst)
        soft_reset_req |-> $past(cfg_we && cfg_wdata[CFG_SRST]));

    p_soft_reset_issue_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[CFG_SRST]) |=> soft_reset_req);

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_ptr));
endmodule

bind bim_top bim_checker u_bim_checker (
    .clk              (clk),
    .rst              (rst),
    .bus_is_byte      (bus_is_byte),
    .host_en          (host_en),
    .host_we          (host_we),
    .host_addr        (host_addr),
    .host_rdata       (host_rdata),
    .cfg_we           (cfg_we),
    .cfg_wdata        (cfg_wdata),
    .cfg_ptr          (cfg_ptr),
    .soft_reset_req   (soft_reset_req),
    .seq_running      (seq_running),
    .access_violation (access_violation)
);

// File: tb/test_bim_top.sv
module test_bim_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_is_byte;
    logic        host_en;
    logic        host_we;
    logic [4:0]  host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [1:0]  cfg_ptr;
    logic        soft_reset_req;
    logic        seq_running;
    logic        access_violation;
    logic [2:0]  seq_idx;
    logic [47:0] seq_instr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [47:0] model [8];

    always #2 clk = ~clk;

    bim_top i_bim_top (
        .clk(clk), .rst(rst), .bus_is_byte(bus_is_byte), .host_en(host_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_ptr(cfg_ptr), .soft_reset_req(soft_reset_req),
        .seq_running(seq_running), .access_violation(access_violation),
        .seq_idx(seq_idx), .seq_instr(seq_instr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] ptr, input logic srst, input logic vclr);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 16'h0;
        cfg_wdata[9:8] = ptr;
        cfg_wdata[1]   = srst;
        cfg_wdata[2]   = vclr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_en = 1'b0;
    endtask

    task automatic seq_rd(input int idx, output logic [47:0] v);
        @(negedge clk);
        seq_idx = 3'(idx);
        @(negedge clk);
        v = seq_instr;
    endtask

    task automatic check_store(input string req);
        logic [47:0] v;
        for (int i = 0; i < 8; i++) begin
            seq_rd(i, v);
            check(req, 64'(v), 64'(model[i]));
        end
    endtask

    task automatic t_reset;
        logic [47:0] v;
        check("R1 rdata", 64'(host_rdata), 64'h0);
        check("R1 ptr", 64'(cfg_ptr), 64'h0);
        check("R1 viol", 64'(access_violation), 64'h0);
        check("R1 srst", 64'(soft_reset_req), 64'h0);
        for (int i = 0; i < 8; i++) begin
            seq_rd(i, v);
            check("R1 store", 64'(v), 64'h0);
        end
    endtask

    task automatic t_word_mode;
        logic [15:0] d;
        bus_is_byte = 1'b0;
        cfg_write(2'b00, 1'b0, 1'b0);
        check("R10 ptr00", 64'(cfg_ptr), 64'h0);
        for (int i = 0; i < 8; i++) begin
            // odd A0 on odd indices: must be ignored in 16-bit mode
            host_wr({4'(i), 1'(i)}, 16'hA000 + 16'(i * 16'h111));
            model[i][15:0] = 16'hA000 + 16'(i * 16'h111);
        end
        for (int i = 7; i >= 0; i--) begin
            host_rd({4'(i), 1'b0}, d);
            check("R2 readback", 64'(d), 64'(model[i][15:0]));
        end
        check_store("R2 store");
    endtask

    task automatic t_sections;
        logic [47:0] v;
        cfg_write(2'b01, 1'b0, 1'b0);
        check("R10 ptr01", 64'(cfg_ptr), 64'h1);
        host_wr(5'b00110, 16'h1234);
        model[3][31:16] = 16'h1234;
        cfg_write(2'b10, 1'b0, 1'b0);
        host_wr(5'b00110, 16'h5678);
        model[3][47:32] = 16'h5678;
        seq_rd(3, v);
        check("R3 layout", 64'(v), 64'(model[3]));
        check_store("R3 neighbours");
    endtask

    task automatic t_byte_mode;
        logic [15:0] d;
        bus_is_byte = 1'b1;
        cfg_write(2'b01, 1'b0, 1'b0);
        host_wr(5'b00110, 16'h77CD);
        model[3][23:16] = 8'hCD;
        check_store("R4 low byte only");
        host_wr(5'b00111, 16'h55AB);
        model[3][31:24] = 8'hAB;
        check_store("R4 high byte only");
        host_rd(5'b00110, d);
        check("R4 read low", 64'(d), 64'h00CD);
        host_rd(5'b00111, d);
        check("R4 read high", 64'(d), 64'h00AB);
        host_rd(5'b01111, d);
        check("R4 read idx7 high", 64'(d), 64'(model[7][31:24]));
        bus_is_byte = 1'b0;
        host_rd(5'b00110, d);
        check("R4 word view", 64'(d), 64'hABCD);
    endtask

    task automatic t_reserved;
        logic [15:0] d;
        cfg_write(2'b11, 1'b0, 1'b0);
        host_wr(5'b00010, 16'hDEAD);
        host_rd(5'b00010, d);
        check("R5 read zero", 64'(d), 64'h0);
        check_store("R5 no write");
    endtask

    task automatic t_out_of_range;
        logic [15:0] d;
        cfg_write(2'b00, 1'b0, 1'b0);
        bus_is_byte = 1'b0;
        host_wr(5'b10000, 16'hFFFF);
        host_rd(5'b10000, d);
        check("R6 word read zero", 64'(d), 64'h0);
        bus_is_byte = 1'b1;
        host_wr(5'b11111, 16'h00EE);
        host_rd(5'b11111, d);
        check("R6 byte read zero", 64'(d), 64'h0);
        bus_is_byte = 1'b0;
        check_store("R6 no write");
    endtask

    task automatic t_latency;
        @(negedge clk);
        seq_idx = 3'd1;
        @(negedge clk);
        check("R7 idx1", 64'(seq_instr), 64'(model[1]));
        seq_idx = 3'd6;
        @(posedge clk);
        #1;
        check("R7 idx6 after edge", 64'(seq_instr), 64'(model[6]));
    endtask

    task automatic t_violation;
        @(negedge clk);
        seq_running = 1'b1;
        host_wr(5'b01010, 16'h0F0F);
        model[5][15:0] = 16'h0F0F;
        seq_running = 1'b0;
        check("R8 set", 64'(access_violation), 64'h1);
        repeat (3) @(negedge clk);
        check("R8 sticky", 64'(access_violation), 64'h1);
        check_store("R8 access completes");
        cfg_write(2'b00, 1'b0, 1'b1);
        check("R8 cleared", 64'(access_violation), 64'h0);
        // clear and a new violation in the same cycle: set wins
        @(negedge clk);
        seq_running = 1'b1; host_en = 1'b1; host_we = 1'b0; host_addr = 5'b0;
        cfg_we = 1'b1; cfg_wdata = 16'h0004;
        @(negedge clk);
        host_en = 1'b0; cfg_we = 1'b0; seq_running = 1'b0;
        check("R8 set over clear", 64'(access_violation), 64'h1);
        cfg_write(2'b00, 1'b0, 1'b1);
    endtask

    task automatic t_soft_reset;
        check("R9 idle", 64'(soft_reset_req), 64'h0);
        cfg_write(2'b00, 1'b1, 1'b0);
        check("R9 pulse", 64'(soft_reset_req), 64'h1);
        @(negedge clk);
        check("R9 one cycle", 64'(soft_reset_req), 64'h0);
        check("R10 ptr held", 64'(cfg_ptr), 64'h0);
    endtask

    initial begin
        rst = 1'b1; bus_is_byte = 1'b0; host_en = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0; cfg_we = 1'b0; cfg_wdata = '0;
        seq_running = 1'b0; seq_idx = '0;
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_mode();
        t_sections();
        t_byte_mode();
        t_reserved();
        t_out_of_range();
        t_latency();
        t_violation();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule